// File: doc/BRIEF.md
# Bit-Addressable General-Purpose Pin Bank

This block is a bank of general-purpose pins behind a small word-addressed register interface. A pin's direction is set and cleared through two separate strobe registers. A write touches only the pins whose data bit is 1, so software never needs a read-modify-write to change one pin. Output levels are loaded through two half-bank registers. Each of these carries a write mask in its upper sixteen bits and the new levels in its lower sixteen. Only the masked pins change, so several agents can drive different pins without a lock.

Each output latch keeps its value whatever the pin's direction. Software can therefore load a level first and then turn the driver on without a glitch. Pin inputs pass through a two-stage synchronizer before software can read them. The pad cells receive the latch values and a per-pin driver enable.

Top module: `gpb_port`

## Requirements
- R1: While the external reset is asserted, and after it is released, every pin is an input (`pin_oe` all 0), every output latch holds 0 and `rdata` is 0.
- R2: A write to word 0 (byte offset 0x00) turns into an output every pin whose `wdata` bit is 1. Pins whose bit is 0 keep their direction. Data bits at or above `N_PINS` are ignored.
- R3: A write to word 1 (byte offset 0x04) turns into an input every pin whose `wdata` bit is 1. Pins whose bit is 0 keep their direction.
- R4: A write to word 2 (byte offset 0x08) updates the lower half of the pins. For each index i below `N_PINS/2`, when `wdata[16+i]` is 1, latch i takes `wdata[i]`. When that mask bit is 0, latch i keeps its value. The upper-half latches are untouched.
- R5: A write to word 3 (byte offset 0x0C) updates the upper half of the pins in the same way. Mask bit `wdata[16+i]` gates the loading of `wdata[i]` into latch `N_PINS/2+i`. The lower-half latches are untouched.
- R6: An output latch changes only on an R4 or R5 write. Direction writes leave it intact, and `pin_out` presents the latch whether the pin is an input or an output.
- R7: A read of word 4 (byte offset 0x10) returns the pin levels through a two-flop synchronizer. A level applied just after a clock edge shows up in the third read that is issued from then on, one read per cycle. The two reads before it return the prior level.
- R8: A read of word 0 returns the direction vector, with 1 meaning output and upper bits 0.
- R9: A read of word 2 or word 3 returns that half's latch values in the low bits and 0 in all other bits, the mask half included.
- R10: `rdata` is registered. It takes the selected word on the edge where `rd_en` is sampled high. Reads of word 1 and of words 5 to 7 return 0. `rdata` holds its value in cycles without `rd_en`. Register writes take effect at the edge that samples `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address (byte offset / 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | N_PINS | Asynchronous pin levels from the pads |
| pin_out | output | N_PINS | Output latch values to the pads |
| pin_oe | output | N_PINS | Per-pin driver enable, 1 means output |

## Verification
The bench builds the bank with `N_PINS = 8`, which gives four pins per half-bank register. This small size lets it sweep every 8-bit direction-set pattern, each followed by a clear pattern, and every one of the 256 mask/value combinations for each half-bank register. It also sweeps every 8-bit input pattern, reading each one three times in a row to pin down the synchronizer latency. Because the width is narrow, the stray data bits above the pin count and above the half width are live during the sweeps. That shows they are ignored.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

  localparam int unsigned BUS_W    = 32;
  localparam int unsigned MASK_LSB = 16;
  localparam int unsigned IDX_W    = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_DIR_SET = 3'd0,
    IDX_DIR_CLR = 3'd1,
    IDX_OUT_LO  = 3'd2,
    IDX_OUT_HI  = 3'd3,
    IDX_PIN_IN  = 3'd4
  } reg_idx_e;

endpackage

// File: rtl/gpb_rst_sync.sv
module gpb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/gpb_in_sync.sv
module gpb_in_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        sync_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= async_in[g];
        sync_q[g] <= meta_q[g];
      end
    end
  end

  assign sync_out = sync_q;

endmodule

// File: rtl/gpb_ctrl_regs.sv
module gpb_ctrl_regs
  import gpb_pkg::*;
#(
  parameter int unsigned N_PINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_dir_set,
  input  logic              we_dir_clr,
  input  logic              we_out_lo,
  input  logic              we_out_hi,
  input  logic [BUS_W-1:0]  wdata,
  output logic [N_PINS-1:0] dir_q,
  output logic [N_PINS-1:0] out_q
);

  localparam int unsigned HALF = N_PINS / 2;

  logic [N_PINS-1:0] dir_d;
  logic [N_PINS-1:0] out_d;
  logic [N_PINS-1:0] pin_sel;
  logic [HALF-1:0]   mask_f;
  logic              dir_en;
  logic              out_en;

  assign pin_sel = wdata[N_PINS-1:0];
  assign mask_f  = wdata[MASK_LSB +: HALF];
  assign dir_en  = we_dir_set | we_dir_clr;
  assign out_en  = we_out_lo | we_out_hi;

  // Next-state: direction set/clear strobes
  always_comb begin
    dir_d = dir_q;
    if (we_dir_set) dir_d = dir_q | pin_sel;
    if (we_dir_clr) dir_d = dir_q & ~pin_sel;
  end

  // Next-state: mask-qualified half-bank output loads
  always_comb begin
    out_d = out_q;
    for (int i = 0; i < int'(HALF); i++) begin
      if (we_out_lo && mask_f[i]) out_d[i]        = wdata[i];
      if (we_out_hi && mask_f[i]) out_d[HALF + i] = wdata[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (dir_en) begin
      dir_q <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (out_en) begin
      out_q <= out_d;
    end
  end

  p_dir_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we_dir_set |=> ((dir_q & $past(pin_sel)) == $past(pin_sel)));

  p_dir_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we_dir_set |=> ((dir_q & ~$past(pin_sel)) == ($past(dir_q) & ~$past(pin_sel))));

  p_dir_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we_dir_clr |=> ((dir_q & $past(pin_sel)) == '0));

  p_dir_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_dir_set || we_dir_clr) |=> $stable(dir_q));

  p_out_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we_out_lo |=> (((out_q[HALF-1:0] & ~$past(mask_f)) == ($past(out_q[HALF-1:0]) & ~$past(mask_f)))
                   && (out_q[N_PINS-1:HALF] == $past(out_q[N_PINS-1:HALF]))));

  p_out_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we_out_hi |=> (((out_q[N_PINS-1:HALF] & ~$past(mask_f)) == ($past(out_q[N_PINS-1:HALF]) & ~$past(mask_f)))
                   && (out_q[HALF-1:0] == $past(out_q[HALF-1:0]))));

  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_out_lo || we_out_hi) |=> $stable(out_q));

endmodule

// File: rtl/gpb_port.sv
module gpb_port
  import gpb_pkg::*;
#(
  parameter int unsigned N_PINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe
);

  localparam int unsigned HALF = N_PINS / 2;

  logic              rst_n_sync;
  logic [N_PINS-1:0] dir_q;
  logic [N_PINS-1:0] out_q;
  logic [N_PINS-1:0] in_sync;
  logic              we_dir_set;
  logic              we_dir_clr;
  logic              we_out_lo;
  logic              we_out_hi;
  logic [BUS_W-1:0]  rd_word;
  logic [BUS_W-1:0]  rdata_q;
  reg_idx_e          idx;

  assign idx = reg_idx_e'(addr);

  gpb_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  gpb_in_sync #(.WIDTH(N_PINS)) u_in_sync (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .async_in (pin_in),
    .sync_out (in_sync)
  );

  // Write decode
  always_comb begin
    we_dir_set = wr_en && (idx == IDX_DIR_SET);
    we_dir_clr = wr_en && (idx == IDX_DIR_CLR);
    we_out_lo  = wr_en && (idx == IDX_OUT_LO);
    we_out_hi  = wr_en && (idx == IDX_OUT_HI);
  end

  gpb_ctrl_regs #(.N_PINS(N_PINS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .we_dir_set (we_dir_set),
    .we_dir_clr (we_dir_clr),
    .we_out_lo  (we_out_lo),
    .we_out_hi  (we_out_hi),
    .wdata      (wdata),
    .dir_q      (dir_q),
    .out_q      (out_q)
  );

  // Read multiplexer
  always_comb begin
    rd_word = '0;
    case (idx)
      IDX_DIR_SET: rd_word[N_PINS-1:0] = dir_q;
      IDX_OUT_LO:  rd_word[HALF-1:0]   = out_q[HALF-1:0];
      IDX_OUT_HI:  rd_word[HALF-1:0]   = out_q[N_PINS-1:HALF];
      IDX_PIN_IN:  rd_word[N_PINS-1:0] = in_sync;
      default:     rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rd_word;
    end
  end

  assign rdata   = rdata_q;
  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !rd_en |=> $stable(rdata));

  p_rdata_clr_r10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rd_en && (addr == 3'd1)) |=> (rdata == '0));

  p_pad_reset_r1: assert property (@(posedge clk)
    !rst_n_sync |-> ((pin_oe == '0) && (pin_out == '0)));

endmodule

// File: tb/gpb_port_tb.sv
`timescale 1ns/1ps
module gpb_port_tb;

  localparam int NP = 8;
  localparam int HP = NP / 2;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic          rd_en;
  logic [2:0]    addr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic [NP-1:0] pin_in;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;

  int checks = 0;
  int errors = 0;

  logic [NP-1:0] exp_dir;
  logic [NP-1:0] exp_out;

  gpb_port #(.N_PINS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called right after a falling edge; returns at the next falling edge.
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = 32'hDEAD_BEEF;
  endtask

  task automatic rd(input logic [2:0] a);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; pin_in = '0;
    exp_dir = '0; exp_out = '0;
    repeat (3) @(negedge clk);
    // R1: during reset
    check("R1 oe in reset", {24'd0, pin_oe}, 32'd0);
    check("R1 out in reset", {24'd0, pin_out}, 32'd0);
    check("R1 rdata in reset", rdata, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 oe after reset", {24'd0, pin_oe}, 32'd0);
    check("R1 out after reset", {24'd0, pin_out}, 32'd0);
    rd(3'd0); check("R1 dir read", rdata, 32'd0);
    rd(3'd2); check("R1 out lo read", rdata, 32'd0);

    // R2 / R3 / R6 / R8: direction sweep
    for (int v = 0; v < 256; v++) begin
      logic [7:0] clr;
      clr = 8'((v * 37 + 11) & 255);
      wr(3'd0, {24'hA5C3E1, 8'(v)});
      exp_dir = exp_dir | 8'(v);
      check("R2 dir set", {24'd0, pin_oe}, {24'd0, exp_dir});
      wr(3'd1, {24'h5A3C1E, clr});
      exp_dir = exp_dir & ~clr;
      check("R3 dir clear", {24'd0, pin_oe}, {24'd0, exp_dir});
      check("R6 latch kept on dir write", {24'd0, pin_out}, {24'd0, exp_out});
      if ((v % 16) == 0) begin
        rd(3'd0);
        check("R8 dir readback", rdata, {24'd0, exp_dir});
      end
    end

    // R6: load while input, then enable driver
    wr(3'd1, 32'h0000_00FF); exp_dir = '0;
    wr(3'd2, 32'h000F_0005); exp_out[3:0] = 4'h5;
    check("R6 latch loaded while input", {24'd0, pin_out}, {24'd0, exp_out});
    wr(3'd0, 32'h0000_000F); exp_dir = 8'h0F;
    check("R6 latch after switching to output", {24'd0, pin_out}, {24'd0, exp_out});
    check("R6 oe follows dir", {24'd0, pin_oe}, {24'd0, exp_dir});

    // R4 / R5 / R9: masked half-bank sweeps
    for (int m = 0; m < 16; m++) begin
      for (int v = 0; v < 16; v++) begin
        logic [3:0] mk;
        logic [3:0] vl;
        mk = 4'(m); vl = 4'(v);
        wr(3'd2, {12'hABC, mk, 12'h963, vl});
        for (int i = 0; i < HP; i++) if (mk[i]) exp_out[i] = vl[i];
        check("R4 low half load", {24'd0, pin_out}, {24'd0, exp_out});
        wr(3'd3, {12'h6D2, mk, 12'h4F0, ~vl});
        for (int i = 0; i < HP; i++) if (mk[i]) exp_out[HP + i] = ~vl[i];
        check("R5 high half load", {24'd0, pin_out}, {24'd0, exp_out});
        check("R6 dir kept on out write", {24'd0, pin_oe}, {24'd0, exp_dir});
      end
      rd(3'd2); check("R9 low half read", rdata, {28'd0, exp_out[3:0]});
      rd(3'd3); check("R9 high half read", rdata, {28'd0, exp_out[7:4]});
    end

    // R10: unmapped words read zero, rdata holds without rd_en
    wr(3'd0, 32'h0000_00FF); exp_dir = 8'hFF;
    for (int a = 5; a < 8; a++) begin
      rd(3'(a)); check("R10 unmapped read", rdata, 32'd0);
    end
    rd(3'd1); check("R10 clear-strobe word reads zero", rdata, 32'd0);
    rd(3'd0); check("R10 dir read", rdata, 32'h0000_00FF);
    wr(3'd1, 32'h0000_000F); exp_dir = 8'hF0;
    @(negedge clk);
    check("R10 rdata holds", rdata, 32'h0000_00FF);

    // R7: input synchronizer latency sweep
    begin
      logic [7:0] prev;
      prev = '0;
      for (int v = 1; v < 257; v++) begin
        logic [7:0] nv;
        nv = 8'(v ^ (v >> 1));
        pin_in = nv;
        rd(3'd4); check("R7 first read old", rdata, {24'd0, prev});
        rd(3'd4); check("R7 second read old", rdata, {24'd0, prev});
        rd(3'd4); check("R7 third read new", rdata, {24'd0, nv});
        prev = nv;
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule